// File: doc/BRIEF.md
# Timer Clock Source Selector with Prescaler and Gating

This block is the clock front end of a multi-channel timer/counter unit. It runs on one system clock. Three source-tick inputs arrive already synchronised to that clock: a peripheral-rate tick, a slow real-time tick and an external-reference tick. For every slot the block produces one divided tick-enable pulse. There are `NUM_CH` timer channels (6 or 8), plus one OS-timer slot and one watchdog slot. Downstream counters, comparators and interrupt logic advance on these pulses.

Each slot has a small control word. The word chooses one source through a one-hot field and sets a power-of-four prescaler. A shared gate vector starts or stops each slot. It is changed through a stop-set word and a stop-clear word, each written with a bit mask, and it is read back through a status word. All of these are reached through a plain word-addressed write/read port. Reads are combinational on the address.

Top module: `tclk_front`

## Requirements
- R1: After reset every control word reads 0, and the gate status reads all existing slot bits as 1 (stopped). With the default of 8 channels the status reads 0x180FF. No tick pulse is produced while a slot is stopped.
- R2: In a control word, bits 2:0 select the source one-hot. Bit 0 selects the peripheral tick (`src_tick_i[0]`), bit 1 the real-time tick (`src_tick_i[1]`) and bit 2 the external tick (`src_tick_i[2]`). A slot counts only ticks of its selected source.
- R3: A slot whose selection field has no bit set, or more than one bit set, produces no pulses.
- R4: Control-word bits 5:3 hold the prescale value p. A running slot pulses once every 4^p selected ticks (/1, /4, /16, /64, /256, /1024). A written p above 5 is stored and read back as 5. Bits 31:6 read 0.
- R5: Writing word 13 (stop-set) with bit k = 1 stops gate bit k. Bits written 0 are left unchanged.
- R6: Writing word 14 (stop-clear) with bit k = 1 makes gate bit k run. Bits written 0 are left unchanged.
- R7: Word 12 reads the gate vector, with 1 meaning stopped. Bits 0 to NUM_CH-1 belong to channels 0 to NUM_CH-1, bit 15 to the OS-timer slot and bit 16 to the watchdog slot.
- R8: Gate bits of channels that do not exist (6 and 7 when NUM_CH = 6) read 0 and ignore writes. Control words of absent channels read 0.
- R9: Writing a slot's control word restarts its prescale count from zero. A tick arriving in the write cycle is discarded, and no pulse results from it.
- R10: After a slot is released from stopped, its first pulse comes only after a full 4^p selected ticks.
- R11: Each pulse is one system-clock cycle wide. It appears in the cycle after the tick that completes the division period.
- R12: Words 0 to 7 are the channel control words, word 8 is the OS-timer control word and word 9 is the watchdog control word. All of them share the layout of R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 3 | Synchronised source ticks: [0] peripheral, [1] real-time, [2] external |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ch_tick_o | output | NUM_CH | Divided tick pulse per timer channel |
| ost_tick_o | output | 1 | Divided tick pulse of the OS-timer slot |
| wdg_tick_o | output | 1 | Divided tick pulse of the watchdog slot |

## Verification
The assertions take the source ticks to be already synchronous single-cycle enables. They also assume the prescale field changes only through a control-word write, so the count never exceeds the period limit. The bench drives ticks only at falling edges, from a random 3-bit pattern per cycle. Every control and gate change goes through the register port, and the bench never forces internal state. Because stopped slots and restarting writes must silence the output, the bench places register writes between tick cycles and also in cycles with ticks active.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

    localparam int SRC_N    = 3;
    localparam int PRE_W    = 3;
    localparam int PRE_MAX  = 5;
    localparam int CNT_W    = 2 * PRE_MAX;
    localparam int GATE_W   = 17;
    localparam int GATE_OST = 15;
    localparam int GATE_WDG = 16;

    localparam int ADR_OST  = 8;
    localparam int ADR_WDG  = 9;
    localparam int ADR_STAT = 12;
    localparam int ADR_SET  = 13;
    localparam int ADR_CLR  = 14;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SRC_N-1:0] sel;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [PRE_W-1:0] clamp_pre(input logic [PRE_W-1:0] p);
        return (p > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : p;
    endfunction

    function automatic logic [CNT_W-1:0] period_last(input logic [PRE_W-1:0] p);
        logic [CNT_W:0] one_w;
        logic [CNT_W:0] full;
        one_w = {{CNT_W{1'b0}}, 1'b1};
        full  = one_w << {clamp_pre(p), 1'b0};
        return CNT_W'(full - one_w);
    endfunction

    function automatic logic sel_ok(input logic [SRC_N-1:0] s);
        logic ok;
        ok = 1'b0;
        for (int i = 0; i < SRC_N; i++) begin
            if (s == SRC_N'(1 << i)) ok = 1'b1;
        end
        return ok;
    endfunction

endpackage

// File: rtl/tclk_regs.sv
module tclk_regs
    import tclk_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    localparam int SLOTS = NUM_CH + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        rdata_o,
    output ctl_t [SLOTS-1:0]         ctl_o,
    output logic [SLOTS-1:0]         stop_o,
    output logic [SLOTS-1:0]         restart_o
);

    function automatic logic [GATE_W-1:0] gate_mask(input int n);
        logic [GATE_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        m[GATE_OST] = 1'b1;
        m[GATE_WDG] = 1'b1;
        return m;
    endfunction

    function automatic int slot_addr(input int s);
        if (s < NUM_CH)  return s;
        if (s == NUM_CH) return ADR_OST;
        return ADR_WDG;
    endfunction

    function automatic int slot_gate(input int s);
        if (s < NUM_CH)  return s;
        if (s == NUM_CH) return GATE_OST;
        return GATE_WDG;
    endfunction

    localparam logic [GATE_W-1:0] GMASK = gate_mask(NUM_CH);

    typedef struct packed {
        ctl_t [SLOTS-1:0]  ctl;
        logic [GATE_W-1:0] gate;
    } regs_t;

    regs_t r_d, r_q;
    logic [SLOTS-1:0]  restart_d;
    logic [GATE_W-1:0] wmask;
    ctl_t              wctl;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:GATE_W];

    always_comb begin
        wmask     = wdata_i[GATE_W-1:0] & GMASK;
        wctl.sel  = wdata_i[SRC_N-1:0];
        wctl.pre  = clamp_pre(wdata_i[SRC_N +: PRE_W]);
        r_d       = r_q;
        restart_d = '0;
        if (we_i) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (int'(addr_i) == slot_addr(s)) begin
                    r_d.ctl[s]   = wctl;
                    restart_d[s] = 1'b1;
                end
            end
            if (int'(addr_i) == ADR_SET) r_d.gate = r_q.gate | wmask;
            if (int'(addr_i) == ADR_CLR) r_d.gate = r_q.gate & ~wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctl  <= '0;
            r_q.gate <= GMASK;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (int'(addr_i) == slot_addr(s))
                rdata_o = {{(DATA_W-CTL_W){1'b0}}, r_q.ctl[s]};
        end
        if (int'(addr_i) == ADR_STAT)
            rdata_o = {{(DATA_W-GATE_W){1'b0}}, r_q.gate};
    end

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            ctl_o[s]  = r_q.ctl[s];
            stop_o[s] = r_q.gate[slot_gate(s)];
        end
        restart_o = restart_d;
    end

    AST_SET_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && int'(addr_i) == ADR_SET) |=>
        ((r_q.gate & $past(wdata_i[GATE_W-1:0] & GMASK)) == $past(wdata_i[GATE_W-1:0] & GMASK))); // R5

    AST_CLR_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && int'(addr_i) == ADR_CLR) |=>
        ((r_q.gate & $past(wdata_i[GATE_W-1:0] & GMASK)) == '0)); // R6

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i) |=> $stable(r_q.gate)); // R5

endmodule

// File: rtl/tclk_divider.sv
module tclk_divider
    import tclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_tick_i,
    input  ctl_t             ctl_i,
    input  logic             stop_i,
    input  logic             restart_i,
    output logic             pulse_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } div_t;

    div_t             d, q;
    logic             sel_tick;
    logic [CNT_W-1:0] last;

    always_comb begin
        sel_tick = sel_ok(ctl_i.sel) && ((ctl_i.sel & src_tick_i) != '0);
        last     = period_last(ctl_i.pre);
        d        = q;
        d.pulse  = 1'b0;
        if (restart_i || stop_i) begin
            d.cnt = '0;
        end else if (sel_tick) begin
            if (q.cnt >= last) begin
                d.cnt   = '0;
                d.pulse = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pulse_o = q.pulse;

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !pulse_o); // R5

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !pulse_o); // R9

    AST_BAD_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ctl_i.sel) != 1) |=> !pulse_o); // R3

    AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past((ctl_i.sel & src_tick_i) != '0)); // R2

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= last); // R4

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o && ctl_i.pre != '0 |=> !pulse_o); // R11

endmodule

// File: rtl/tclk_front.sv
module tclk_front
    import tclk_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        src_tick_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] ch_tick_o,
    output logic              ost_tick_o,
    output logic              wdg_tick_o
);

    localparam int SLOTS = NUM_CH + 2;

    ctl_t [SLOTS-1:0] ctl;
    logic [SLOTS-1:0] stop;
    logic [SLOTS-1:0] restart;
    logic [SLOTS-1:0] ticks;

    tclk_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (32)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .rdata_o   (bus_rdata),
        .ctl_o     (ctl),
        .stop_o    (stop),
        .restart_o (restart)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        tclk_divider u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_tick_i (src_tick_i),
            .ctl_i      (ctl[s]),
            .stop_i     (stop[s]),
            .restart_i  (restart[s]),
            .pulse_o    (ticks[s])
        );
    end

    assign ch_tick_o  = ticks[NUM_CH-1:0];
    assign ost_tick_o = ticks[NUM_CH];
    assign wdg_tick_o = ticks[NUM_CH+1];

endmodule

// File: tb/sim_tclk_front.sv
module sim_tclk_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tk = '0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  ch_t;
    logic        ost_t, wdg_t;

    logic        u1_we = 1'b0;
    logic [4:0]  u1_addr = '0;
    logic [31:0] u1_wdata = '0;
    logic [31:0] u1_rdata;
    logic [5:0]  u1_ch;
    logic        u1_ost, u1_wdg;

    always #4 clk = ~clk;

    tclk_front #(.NUM_CH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .src_tick_i(tk),
        .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .ch_tick_o(ch_t), .ost_tick_o(ost_t), .wdg_tick_o(wdg_t)
    );

    tclk_front #(.NUM_CH(6)) u1 (
        .clk(clk), .rst_n(rst_n), .src_tick_i(3'b000),
        .bus_we(u1_we), .bus_addr(u1_addr), .bus_wdata(u1_wdata), .bus_rdata(u1_rdata),
        .ch_tick_o(u1_ch), .ost_tick_o(u1_ost), .wdg_tick_o(u1_wdg)
    );

    int checks = 0;
    int bad = 0;
    string cur_req = "R1";

    logic [2:0]  m_sel [10];
    logic [2:0]  m_pre [10];
    int          m_cnt [10];
    logic [16:0] m_gate;
    logic [9:0]  exp_q [$];
    logic [9:0]  e_v;

    function automatic int gbit(input int s);
        return (s < 8) ? s : ((s == 8) ? 15 : 16);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv, input string what);
        checks++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    // driver: one cycle of stimulus, pushes the expected outputs of the next edge
    task automatic step(input logic [2:0] t, input logic w, input logic [4:0] a, input logic [31:0] d);
        logic [9:0] ex;
        @(negedge clk);
        tk = t; we = w; addr = a; wdata = d;
        ex = '0;
        for (int s = 0; s < 10; s++) begin
            if ((w && int'(a) == s) || m_gate[gbit(s)]) begin
                m_cnt[s] = 0;
            end else if ($countones(m_sel[s]) == 1 && (m_sel[s] & t) != 3'b000) begin
                if (m_cnt[s] == (1 << (2 * int'(m_pre[s]))) - 1) begin
                    ex[s] = 1'b1;
                    m_cnt[s] = 0;
                end else begin
                    m_cnt[s]++;
                end
            end
        end
        exp_q.push_back(ex);
        if (w) begin
            if (int'(a) < 10) begin
                m_sel[a] = d[2:0];
                m_pre[a] = (d[5:3] > 3'd5) ? 3'd5 : d[5:3];
            end
            if (a == 5'd13) m_gate = m_gate | (d[16:0] & 17'h180FF);
            if (a == 5'd14) m_gate = m_gate & ~(d[16:0] & 17'h180FF);
        end
        #1;
    endtask

    task automatic rd(input logic [4:0] a, input string req);
        logic [31:0] ex;
        step(3'b000, 1'b0, a, 32'h0);
        if (int'(a) < 10) ex = {26'b0, m_pre[a], m_sel[a]};
        else if (a == 5'd12) ex = {15'b0, m_gate};
        else ex = '0;
        check(req, rdata, ex, $sformatf("read word %0d", a));
    endtask

    task automatic u1_op(input logic w, input logic [4:0] a, input logic [31:0] d,
                         input logic [31:0] ex, input string req);
        u1_we = w; u1_addr = a; u1_wdata = d;
        step(3'b000, 1'b0, 5'd0, 32'h0);
        if (!w) check(req, u1_rdata, ex, $sformatf("6-ch read word %0d", a));
        u1_we = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(3'($urandom_range(0, 7)), 1'b0, 5'd0, 32'h0);
    endtask

    // monitor: compares each cycle's pulses with the scoreboard entry
    always @(posedge clk) begin
        #2;
        if (rst_n && exp_q.size() > 0) begin
            e_v = exp_q.pop_front();
            check(cur_req, {22'b0, wdg_t, ost_t, ch_t}, {22'b0, e_v}, "tick pulses");
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 10; s++) begin
            m_sel[s] = '0; m_pre[s] = '0; m_cnt[s] = 0;
        end
        m_gate = 17'h180FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, stopped slots are silent
        cur_req = "R1";
        for (int a = 0; a < 10; a++) rd(5'(a), "R1");
        rd(5'd12, "R1");
        run(40);

        // R12, R2, R3, R4: configure every slot
        cur_req = "R12";
        step(3'b000, 1'b1, 5'd0, 32'hFFFF_FFC1);   // peripheral /1, upper bits dropped
        step(3'b111, 1'b1, 5'd1, 32'h0000_000A);   // real-time /4
        step(3'b000, 1'b1, 5'd2, 32'h0000_0014);   // external /16
        step(3'b000, 1'b1, 5'd3, 32'h0000_0000);   // R3 no source
        step(3'b000, 1'b1, 5'd4, 32'h0000_0003);   // R3 two sources
        step(3'b000, 1'b1, 5'd5, 32'h0000_0039);   // R4 prescale 7 -> 5
        step(3'b000, 1'b1, 5'd6, 32'h0000_001A);   // real-time /64
        step(3'b000, 1'b1, 5'd7, 32'h0000_0004);   // external /1
        step(3'b000, 1'b1, 5'd8, 32'h0000_0009);   // OS-timer peripheral /4
        step(3'b000, 1'b1, 5'd9, 32'h0000_0004);   // watchdog external /1
        for (int a = 0; a < 10; a++) rd(5'(a), "R4");
        rd(5'd10, "R12");
        check("R4", {26'b0, m_pre[5], m_sel[5]}, 32'h29, "model clamp");

        // still stopped: ticks must not pass
        cur_req = "R1";
        run(30);

        // R6, R10: release every slot, including absent bits
        cur_req = "R10";
        step(3'b000, 1'b1, 5'd14, 32'h0001_FFFF);
        rd(5'd12, "R6");
        run(2500);

        // R5: stop two channels, zero bits unchanged
        cur_req = "R5";
        step(3'b101, 1'b1, 5'd13, 32'h0000_0005);
        rd(5'd12, "R7");
        run(300);
        step(3'b111, 1'b1, 5'd13, 32'h0001_8000);
        rd(5'd12, "R7");
        run(200);

        // R6, R10: release again, counts start from zero
        cur_req = "R6";
        step(3'b000, 1'b1, 5'd14, 32'h0001_8005);
        rd(5'd12, "R6");
        run(1500);

        // R9: rewrite control words while ticks are active
        cur_req = "R9";
        for (int i = 0; i < 20; i++) begin
            step(3'b111, 1'b1, 5'd1, 32'h0000_000A);
            run(3);
        end
        step(3'b111, 1'b1, 5'd2, 32'h0000_0001);
        run(400);

        // R11: steady /1 stream on the external source
        cur_req = "R11";
        for (int i = 0; i < 50; i++) step(3'b100, 1'b0, 5'd0, 32'h0);
        run(2000);

        // R8: six-channel variant
        cur_req = "R8";
        u1_op(1'b0, 5'd12, 32'h0, 32'h0001_803F, "R8");
        u1_op(1'b1, 5'd14, 32'h0000_00FF, 32'h0, "R8");
        u1_op(1'b0, 5'd12, 32'h0, 32'h0001_8000, "R8");
        u1_op(1'b1, 5'd13, 32'h0000_00C0, 32'h0, "R8");
        u1_op(1'b0, 5'd12, 32'h0, 32'h0001_8000, "R8");
        u1_op(1'b1, 5'd6, 32'h0000_0011, 32'h0, "R8");
        u1_op(1'b0, 5'd6, 32'h0, 32'h0, "R8");
        u1_op(1'b1, 5'd9, 32'h0000_003C, 32'h0, "R12");
        u1_op(1'b0, 5'd9, 32'h0, 32'h0000_002C, "R12");

        run(5);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule